// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 23 general-purpose input pins arranged in three groups of 8, 7 and 8 pins. Every pin has its own mask bit. A change of level in either direction on an unmasked pin sets the pending flag of that pin's group. A group raises its interrupt request only while its pending flag, its group enable and the global interrupt enable are all one.

Software reaches the block over a simple byte-wide register bus. The bus gives access to three mask registers, a control register that holds the group enables, and a flag register. A pending flag clears in one of two ways. Software can write a one to its bit in the flag register. Or an acknowledge pulse, which stands for vector entry, clears the highest-priority pending group, and group 0 has the highest priority.

Each pin passes through a two-flop synchronizer before edge detection, so the pins may be driven asynchronously to the clock.

Top module: `pin_toggle_irq`

## Requirements
- R1: A level change in either direction on a pin whose mask bit is one sets the pending flag of that pin's group. The groups are: group 0 = `grp0_pins_i[7:0]`, group 1 = `grp1_pins_i[6:0]`, group 2 = `grp2_pins_i[7:0]`. Group g's flag is bit g of the flag register.
- R2: A pin whose mask bit is zero never sets a pending flag, whatever the other mask bits of its group hold.
- R3: `irq_o[g]` is one only when group g's pending flag, its enable (control register bit g) and `gie_i` were all one in the previous clock cycle.
- R4: A one-cycle pulse on `irq_ack_i` clears only the lowest-numbered pending flag. Group 0 has the highest priority. A pulse while no flag is pending changes nothing.
- R5: Writing to the flag register clears each flag whose data bit is one. Flags whose data bit is zero keep their value.
- R6: When a new enabled change arrives in the same cycle as a clear of the same flag, the flag stays set. This holds whether the clear comes from a write of one or from an acknowledge.
- R7: Bit 7 of the group 1 mask register is reserved. It always reads zero, and writes to it have no effect.
- R8: The mask registers are at 0x6B (group 0), 0x6C (group 1) and 0x6D (group 2). Bit n of a mask register controls pin n of that group. All mask registers reset to zero, and a value written can be read back.
- R9: The control register is at 0x70, with the enables in bits 2..0. The flag register is at 0x71, with the flags in bits 2..0. Both reset to zero, and their bits 7..3 read zero. Any unmapped address reads zero. Read data appears on `bus_rdata_o` one clock after the address is presented.
- R10: Take a pin change applied before clock edge k, with the group enable and `gie_i` set. The pending flag sets at edge k+2, and `irq_o` rises at edge k+3, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp0_pins_i | input | 8 | Group 0 pins, asynchronous |
| grp1_pins_i | input | 7 | Group 1 pins, asynchronous |
| grp2_pins_i | input | 8 | Group 2 pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Acknowledge pulse (vector entry) |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 3 | Per-group interrupt requests |

## Verification
The bench builds the block with its default parameters: group widths 8, 7 and 8, two synchronizer stages, and 8-bit address and data. At these sizes the bench can sweep the whole input space:
- every pin is toggled in both directions, once with only its own mask bit set and once with every mask bit except its own set;
- all 256 data values are written to each mask register;
- every combination of the three pending flags, the three enables and the global enable is tried against `irq_o`.

The single-cycle races between a new change and a clear are placed on the exact edge where the flag sets, and placed again one cycle later as a control.

// File: rtl/pin_toggle_pkg.sv
package pin_toggle_pkg;
  localparam int NUM_GRP = 3;
  typedef logic [NUM_GRP-1:0] grp_vec_t;

  // keep only the lowest set bit (highest priority group)
  function automatic grp_vec_t lowest_one(grp_vec_t v);
    return v & (~v + grp_vec_t'(1));
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pt_sync_edge.sv
module pt_sync_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] chg
);
  logic [STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= din;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign chg = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pt_regs.sv
module pt_regs
  import pin_toggle_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int G0_W   = 8,
  parameter int G1_W   = 7,
  parameter int G2_W   = 8,
  parameter logic [ADDR_W-1:0] MASK0_ADDR = 8'h6B,
  parameter logic [ADDR_W-1:0] MASK1_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] MASK2_ADDR = 8'h6D,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h70,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 8'h71,
  localparam int MAXW = max3(G0_W, G1_W, G2_W)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          we_i,
  input  grp_vec_t                      flag_i,
  output logic [NUM_GRP-1:0][MAXW-1:0]  mask_o,
  output grp_vec_t                      en_o,
  output grp_vec_t                      w1c_o,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam int GRP_W [NUM_GRP] = '{G0_W, G1_W, G2_W};
  localparam logic [ADDR_W-1:0] MASK_ADDR [NUM_GRP] = '{MASK0_ADDR, MASK1_ADDR, MASK2_ADDR};

  function automatic logic [MAXW-1:0] valid_bits(int g);
    logic [MAXW-1:0] v;
    v = '0;
    for (int i = 0; i < MAXW; i++) v[i] = (i < GRP_W[g]);
    return v;
  endfunction

  logic [NUM_GRP-1:0][MAXW-1:0] mask_q;
  grp_vec_t                     en_q;
  logic [DATA_W-1:0]            rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      for (int g = 0; g < NUM_GRP; g++)
        if (addr_i == MASK_ADDR[g]) mask_q[g] <= wdata_i[MAXW-1:0] & valid_bits(g);
      if (addr_i == CTRL_ADDR) en_q <= wdata_i[NUM_GRP-1:0];
    end
  end

  assign w1c_o = (we_i && addr_i == FLAG_ADDR) ? wdata_i[NUM_GRP-1:0] : '0;

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (addr_i == MASK_ADDR[g]) rd_next = DATA_W'(mask_q[g]);
    if (addr_i == CTRL_ADDR) rd_next = DATA_W'(en_q);
    if (addr_i == FLAG_ADDR) rd_next = DATA_W'(flag_i);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/pt_flags.sv
module pt_flags
  import pin_toggle_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  grp_vec_t hit_i,
  input  grp_vec_t w1c_i,
  input  logic     ack_i,
  input  grp_vec_t en_i,
  input  logic     gie_i,
  output grp_vec_t flag_o,
  output grp_vec_t irq_o
);
  grp_vec_t flag_q, flag_d, ack_clr;

  always_comb begin
    ack_clr = ack_i ? lowest_one(flag_q) : '0;
    // a fresh event overrides any clear in the same cycle
    flag_d  = (flag_q & ~w1c_i & ~ack_clr) | hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_o  <= '0;
    end else begin
      flag_q <= flag_d;
      irq_o  <= flag_q & en_i & {NUM_GRP{gie_i}};
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import pin_toggle_pkg::*;
#(
  parameter int G0_W        = 8,
  parameter int G1_W        = 7,
  parameter int G2_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] MASK0_ADDR = 8'h6B,
  parameter logic [ADDR_W-1:0] MASK1_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] MASK2_ADDR = 8'h6D,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h70,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 8'h71
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [G0_W-1:0]    grp0_pins_i,
  input  logic [G1_W-1:0]    grp1_pins_i,
  input  logic [G2_W-1:0]    grp2_pins_i,
  input  logic               gie_i,
  input  logic               irq_ack_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               bus_we_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_GRP-1:0] irq_o
);
  localparam int MAXW = max3(G0_W, G1_W, G2_W);

  logic [NUM_GRP-1:0][MAXW-1:0] pins_pad, chg, mask_q;
  grp_vec_t hit, en_q, w1c, flag_q;

  always_comb begin
    pins_pad = '0;
    pins_pad[0][G0_W-1:0] = grp0_pins_i;
    pins_pad[1][G1_W-1:0] = grp1_pins_i;
    pins_pad[2][G2_W-1:0] = grp2_pins_i;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pt_sync_edge #(.W(MAXW), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (pins_pad[g]),
      .chg (chg[g])
    );
    assign hit[g] = |(chg[g] & mask_q[g]);
  end

  pt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .G0_W(G0_W), .G1_W(G1_W), .G2_W(G2_W),
    .MASK0_ADDR(MASK0_ADDR), .MASK1_ADDR(MASK1_ADDR), .MASK2_ADDR(MASK2_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .we_i    (bus_we_i),
    .flag_i  (flag_q),
    .mask_o  (mask_q),
    .en_o    (en_q),
    .w1c_o   (w1c),
    .rdata_o (bus_rdata_o)
  );

  pt_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (hit),
    .w1c_i  (w1c),
    .ack_i  (irq_ack_i),
    .en_i   (en_q),
    .gie_i  (gie_i),
    .flag_o (flag_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/pt_checker.sv
module pt_checker
  import pin_toggle_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     gie_i,
  input logic     ack_i,
  input logic     we_i,
  input grp_vec_t hit,
  input grp_vec_t flag_q,
  input grp_vec_t en_q,
  input grp_vec_t irq_o,
  input logic     rsvd_bit
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst || !armed)
    (|hit) |=> ((flag_q & $past(hit)) == $past(hit))); // R1

  AST_NO_UNPROMPTED_SET: assert property (@(posedge clk) disable iff (rst || !armed)
    ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0)); // R2

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst || !armed)
    (|irq_o) |-> $past(gie_i)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst || !armed)
    ((irq_o & ~$past(en_q)) == '0)); // R3

  AST_ACK_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst || !armed)
    (ack_i && !we_i && hit == '0 && flag_q != '0) |=>
      (($past(flag_q) & ~flag_q) == lowest_one($past(flag_q)))); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsvd_bit); // R7
endmodule

bind pin_toggle_irq pt_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .gie_i    (gie_i),
  .ack_i    (irq_ack_i),
  .we_i     (bus_we_i),
  .hit      (hit),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .irq_o    (irq_o),
  .rsvd_bit (mask_q[1][MAXW-1])
);

// File: tb/sim_pin_toggle_irq.sv
module sim_pin_toggle_irq;
  localparam logic [7:0] A_M0 = 8'h6B, A_M1 = 8'h6C, A_M2 = 8'h6D;
  localparam logic [7:0] A_CTL = 8'h70, A_FLG = 8'h71;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] g0 = '0;
  logic [6:0] g1 = '0;
  logic [7:0] g2 = '0;
  logic       gie = 1'b0, ack = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [2:0] irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pin_toggle_irq u0 (
    .clk(clk), .rst(rst),
    .grp0_pins_i(g0), .grp1_pins_i(g1), .grp2_pins_i(g2),
    .gie_i(gie), .irq_ack_i(ack),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic tgl(input int g, input int b);
    @(negedge clk);
    case (g)
      0: g0[b] = ~g0[b];
      1: g1[b] = ~g1[b];
      default: g2[b] = ~g2[b];
    endcase
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic int wid(input int g);
    return (g == 1) ? 7 : 8;
  endfunction

  function automatic logic [7:0] maddr(input int g);
    return (g == 0) ? A_M0 : (g == 1) ? A_M1 : A_M2;
  endfunction

  // raise the flags named in fp, all masks fully open beforehand
  task automatic make_flags(input logic [2:0] fp);
    wr(A_FLG, 8'h07);
    for (int g = 0; g < 3; g++) if (fp[g]) tgl(g, 0);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, full, m;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state: R8, R9
    rd(A_M0, v);  chk("R8 reset mask0", v, 8'h00);
    rd(A_M1, v);  chk("R8 reset mask1", v, 8'h00);
    rd(A_M2, v);  chk("R8 reset mask2", v, 8'h00);
    rd(A_CTL, v); chk("R9 reset ctrl", v, 8'h00);
    rd(A_FLG, v); chk("R9 reset flag", v, 8'h00);
    chk("R3 reset irq", {5'b0, irq}, 8'h00);

    // unmapped reads: R9
    rd(8'h00, v); chk("R9 unmapped 00", v, 8'h00);
    rd(8'h6A, v); chk("R9 unmapped 6A", v, 8'h00);
    rd(8'h6E, v); chk("R9 unmapped 6E", v, 8'h00);
    rd(8'h72, v); chk("R9 unmapped 72", v, 8'h00);
    rd(8'hFF, v); chk("R9 unmapped FF", v, 8'h00);

    // every mask value: R8, R7
    for (int d = 0; d < 256; d++) begin
      wr(A_M0, 8'(d)); rd(A_M0, v); chk("R8 mask0 readback", v, 8'(d));
      wr(A_M2, 8'(d)); rd(A_M2, v); chk("R8 mask2 readback", v, 8'(d));
      wr(A_M1, 8'(d)); rd(A_M1, v); chk("R7 mask1 bit7 zero", v, 8'(d) & 8'h7F);
    end

    // control and flag reserved bits: R9
    wr(A_CTL, 8'hFF); rd(A_CTL, v); chk("R9 ctrl bits", v, 8'h07);
    wr(A_CTL, 8'h00);

    // per-pin sweep, both directions, own mask on or only others on: R1, R2
    for (int g = 0; g < 3; g++) begin
      for (int b = 0; b < wid(g); b++) begin
        for (int on = 0; on < 2; on++) begin
          full = 8'((1 << wid(g)) - 1);
          m = on ? 8'(1 << b) : (full & ~8'(1 << b));
          wr(maddr(g), m);
          wr(A_FLG, 8'h07);
          for (int dir = 0; dir < 2; dir++) begin
            tgl(g, b);
            settle();
            rd(A_FLG, v);
            if (on != 0) chk("R1 enabled pin sets flag", v, 8'(1 << g));
            else         chk("R2 masked pin ignored", v, 8'h00);
            wr(A_FLG, 8'h07);
          end
        end
      end
      wr(maddr(g), 8'h00);
    end

    // open all masks
    wr(A_M0, 8'hFF); wr(A_M1, 8'h7F); wr(A_M2, 8'hFF);

    // flag register read shows all three, reserved zero: R9
    make_flags(3'b111);
    rd(A_FLG, v); chk("R9 flag bits", v, 8'h07);

    // write-one-to-clear: R5
    wr(A_FLG, 8'h00); rd(A_FLG, v); chk("R5 zero write keeps", v, 8'h07);
    wr(A_FLG, 8'h02); rd(A_FLG, v); chk("R5 clear group1 only", v, 8'h05);
    wr(A_FLG, 8'hF8); rd(A_FLG, v); chk("R5 high bits no effect", v, 8'h05);
    wr(A_FLG, 8'h07); rd(A_FLG, v); chk("R5 clear all", v, 8'h00);

    // acknowledge priority: R4
    make_flags(3'b111);
    pulse_ack(); rd(A_FLG, v); chk("R4 ack clears group0", v, 8'h06);
    pulse_ack(); rd(A_FLG, v); chk("R4 ack clears group1", v, 8'h04);
    pulse_ack(); rd(A_FLG, v); chk("R4 ack clears group2", v, 8'h00);
    pulse_ack(); rd(A_FLG, v); chk("R4 ack with none pending", v, 8'h00);
    make_flags(3'b101);
    pulse_ack(); rd(A_FLG, v); chk("R4 ack skips idle group", v, 8'h04);
    wr(A_FLG, 8'h07);

    // set wins over write-one-to-clear on the same edge: R6
    make_flags(3'b001);
    tgl(0, 3);                       // before edge k
    @(negedge clk); @(negedge clk);  // past k, k+1
    addr = A_FLG; wdata = 8'h01; we = 1'b1;
    @(negedge clk); we = 1'b0;       // write lands at k+2
    rd(A_FLG, v); chk("R6 set beats w1c", v, 8'h01);
    // control: clear one cycle after the set
    tgl(0, 3);
    repeat (3) @(negedge clk);
    addr = A_FLG; wdata = 8'h01; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(A_FLG, v); chk("R5 w1c after set clears", v, 8'h00);

    // set wins over acknowledge on the same edge: R6
    make_flags(3'b001);
    tgl(0, 4);
    @(negedge clk); @(negedge clk);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd(A_FLG, v); chk("R6 set beats ack", v, 8'h01);
    wr(A_FLG, 8'h07);

    // latency from pin to request: R10
    wr(A_CTL, 8'h07); gie = 1'b1;
    @(negedge clk);
    chk("R10 idle irq", {5'b0, irq}, 8'h00);
    tgl(2, 5);
    repeat (3) @(negedge clk);
    chk("R10 irq not before k+3", {5'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R10 irq at k+3", {5'b0, irq}, 8'h04);
    wr(A_FLG, 8'h07);

    // request gating over all flag, enable and global combinations: R3
    for (int fp = 0; fp < 8; fp++) begin
      gie = 1'b0;
      make_flags(3'(fp));
      for (int en = 0; en < 8; en++) begin
        for (int ge = 0; ge < 2; ge++) begin
          gie = ge[0];
          wr(A_CTL, 8'(en));
          @(negedge clk);
          chk("R3 irq gating", {5'b0, irq}, ge ? 8'(fp & en) : 8'h00);
        end
      end
      rd(A_CTL, v); chk("R9 ctrl readback", v, 8'h07);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule